// File: doc/BRIEF.md
# DRAM Activate Spacing Guard

This block sits beside a DRAM command scheduler. It watches every command that goes out: activates, writes that close the page, and refreshes, each tagged with a rank and a bank. For every bank and every rank it works out whether an activate or a refresh may issue on the coming clock edge. The minimum spacings come from configuration inputs counted in core cycles. The block tracks four of them: the normal same-bank activate gap, a longer same-bank gap when the open page was written and closed, a rank-wide hold after a refresh, and a rank-wide hold after an activate to any bank.

The scheduler reads the per-bank and per-rank ready flags to choose its next command. If a command issues while its target is not ready, a one-cycle violation flag rises. The block still records that command, so every later decision stays consistent. A 3-bit posted-CAS additive latency value passes through unchanged for the write-recovery logic further on. A longer post-write spacing is, by convention, programmed as tRCD + (tCL − 1) + BL/2 + tWR + tRP. The block only counts the value it is given.

Top module: `dram_act_guard`

## Requirements
- R1: An activate (cmd_op 2'b01) issued at clock edge t to a rank/bank clears that bank's bank_ready flag. The flag is set again from edge t+cfg_trc onward. A value of 0 or 1 means the bank is ready at the next edge.
- R2: A write with page close (cmd_op 2'b10) to a bank raises that bank's required spacing to the larger of its current spacing and cfg_twrc. The spacing is still measured from that bank's last activate.
- R3: A refresh (cmd_op 2'b11) at edge t to a rank clears bank_ready for all banks of that rank, and clears that rank's rank_ready. Both stay low until edge t+cfg_trfc.
- R4: An activate at edge t clears bank_ready for every bank of the same rank until edge t+cfg_trrd. Ranks other than the target are not affected.
- R5: rank_ready for a rank is high only when every bank in it has passed its same-bank spacing and both of that rank's hold counts have expired.
- R6: When a command reloads a spacing, the new spacing is the larger of the time still remaining and the new requirement. Configuration changes take effect only when a command loads a spacing.
- R7: An activate to a bank whose bank_ready is low, or a refresh to a rank whose rank_ready is low, raises violation for exactly the following cycle. The command is tracked as if it were legal. cmd_op 2'b00 is no command.
- R8: During reset and right after it, all ready flags are high and violation is low.
- R9: tal_out always equals cfg_tal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op | input | 2 | 00 none, 01 activate, 10 write with page close, 11 refresh |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bank | input | BANK_W | Target bank (ignored for refresh) |
| cfg_trc | input | TRC_W | Same-bank activate spacing, cycles |
| cfg_twrc | input | TRC_W | Same-bank spacing after a write with page close, cycles |
| cfg_trfc | input | TRFC_W | Refresh-to-activate/refresh hold, cycles |
| cfg_trrd | input | TRRD_W | Activate-to-activate hold within a rank, cycles |
| cfg_tal | input | TAL_W | Posted-CAS additive latency |
| bank_ready | output | NUM_RANKS*NUM_BANKS | Bank may accept an activate; bit rank*NUM_BANKS+bank |
| rank_ready | output | NUM_RANKS | Rank may accept a refresh |
| violation | output | 1 | Previous cycle's activate or refresh was early |
| tal_out | output | TAL_W | Copy of cfg_tal |

## Verification
Two holds can run out on the same edge: a bank's own same-bank spacing and its rank's cross-bank or refresh hold. A command aimed at that edge must be judged against all of them together. The bench sets cfg_trc, cfg_trrd and cfg_trfc to small, often equal values and fires activates and refreshes at random times. This makes a command land on the exact edge where several holds expire, or one cycle before it. Every cycle, a cycle-accurate bench model of the spacing rules predicts all ready flags and the violation flag for that edge.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_ACT  = 2'b01,
    OP_WRAP = 2'b10,
    OP_REF  = 2'b11
  } cmd_op_e;
endpackage

// File: rtl/act_bank_timer.sv
module act_bank_timer #(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             wrap_i,
  input  logic [AGE_W-1:0] cfg_trc_i,
  input  logic [AGE_W-1:0] cfg_twrc_i,
  output logic             ok_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q, age_d, lim_q, lim_d, rem;
  logic             age_en, lim_en;

  // age counts cycles since the last activate; lim is the spacing needed
  always_comb begin
    rem    = (lim_q > age_q) ? lim_q - age_q : '0;
    age_en = act_i | (age_q != AGE_MAX);
    lim_en = act_i | wrap_i;
    age_d  = act_i ? AGE_W'(1) : age_q + AGE_W'(1);
    if (act_i) lim_d = (cfg_trc_i > rem) ? cfg_trc_i : rem;
    else       lim_d = (cfg_twrc_i > lim_q) ? cfg_twrc_i : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= AGE_MAX;
      lim_q <= '0;
    end else begin
      if (age_en) age_q <= age_d;
      if (lim_en) lim_q <= lim_d;
    end
  end

  assign ok_o = (age_q >= lim_q);

  // R1: an activate with a spacing above one blocks the bank next cycle
  a_r1_act_blocks_bank: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && (cfg_trc_i > AGE_W'(1)) |=> !ok_o);
  // R2: a page-closing write leaves at least cfg_twrc as the spacing
  a_r2_wrap_extends: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i && !act_i |=> lim_q >= $past(cfg_twrc_i));
endmodule

// File: rtl/act_rank_timer.sv
module act_rank_timer #(
  parameter int RFC_W = 8,
  parameter int RRD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             ref_i,
  input  logic [RFC_W-1:0] cfg_trfc_i,
  input  logic [RRD_W-1:0] cfg_trrd_i,
  output logic             ref_clear_o,
  output logic             rrd_clear_o
);
  logic [RFC_W-1:0] ref_q, ref_d, ref_dec, ref_req;
  logic [RRD_W-1:0] rrd_q, rrd_d, rrd_dec, rrd_req;
  logic             ref_en, rrd_en;

  always_comb begin
    ref_dec = (ref_q != '0) ? ref_q - RFC_W'(1) : '0;
    ref_req = (cfg_trfc_i != '0) ? cfg_trfc_i - RFC_W'(1) : '0;
    rrd_dec = (rrd_q != '0) ? rrd_q - RRD_W'(1) : '0;
    rrd_req = (cfg_trrd_i != '0) ? cfg_trrd_i - RRD_W'(1) : '0;
    ref_en  = ref_i | (ref_q != '0);
    rrd_en  = act_i | (rrd_q != '0);
    ref_d   = (ref_i && ref_req > ref_dec) ? ref_req : ref_dec;
    rrd_d   = (act_i && rrd_req > rrd_dec) ? rrd_req : rrd_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      rrd_q <= '0;
    end else begin
      if (ref_en) ref_q <= ref_d;
      if (rrd_en) rrd_q <= rrd_d;
    end
  end

  assign ref_clear_o = (ref_q == '0);
  assign rrd_clear_o = (rrd_q == '0);

  // R3: a refresh with hold above one blocks the rank next cycle
  a_r3_ref_blocks_rank: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i && (cfg_trfc_i > RFC_W'(1)) |=> !ref_clear_o);
  // R4: an activate with hold above one blocks the rank next cycle
  a_r4_act_blocks_rank: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && (cfg_trrd_i > RRD_W'(1)) |=> !rrd_clear_o);
  // R6: without a reload the refresh hold only counts down
  a_r6_ref_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_i && !ref_clear_o |=> ref_q < $past(ref_q));
endmodule

// File: rtl/dram_act_guard.sv
module dram_act_guard #(
  parameter int NUM_RANKS = 8,
  parameter int NUM_BANKS = 8,
  parameter int TRC_W     = 6,
  parameter int TRFC_W    = 8,
  parameter int TRRD_W    = 4,
  parameter int TAL_W     = 3,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM_TGT  = NUM_RANKS * NUM_BANKS
) (
  input  logic [0:0]        clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [TRC_W-1:0]  cfg_trc,
  input  logic [TRC_W-1:0]  cfg_twrc,
  input  logic [TRFC_W-1:0] cfg_trfc,
  input  logic [TRRD_W-1:0] cfg_trrd,
  input  logic [TAL_W-1:0]  cfg_tal,
  output logic [NUM_TGT-1:0]   bank_ready,
  output logic [NUM_RANKS-1:0] rank_ready,
  output logic              violation,
  output logic [TAL_W-1:0]  tal_out
);
  import act_guard_pkg::*;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  cmd_op_e              op;
  logic                 is_act, is_wrap, is_ref;
  logic [NUM_TGT-1:0]   act_hit, wrap_hit, bank_ok;
  logic [NUM_RANKS-1:0] rank_hit, ref_hit, ref_clr, rrd_clr;
  logic                 early, viol_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign op      = cmd_op_e'(cmd_op);
  assign is_act  = (op == OP_ACT);
  assign is_wrap = (op == OP_WRAP);
  assign is_ref  = (op == OP_REF);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign rank_hit[r] = (cmd_rank == RANK_W'(r));
    assign ref_hit[r]  = is_ref & rank_hit[r];

    act_rank_timer #(.RFC_W(TRFC_W), .RRD_W(TRRD_W)) u_rank (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .act_i       (is_act & rank_hit[r]),
      .ref_i       (ref_hit[r]),
      .cfg_trfc_i  (cfg_trfc),
      .cfg_trrd_i  (cfg_trrd),
      .ref_clear_o (ref_clr[r]),
      .rrd_clear_o (rrd_clr[r])
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int IDX = r * NUM_BANKS + b;
      logic bank_hit;
      assign bank_hit      = rank_hit[r] & (cmd_bank == BANK_W'(b));
      assign act_hit[IDX]  = is_act & bank_hit;
      assign wrap_hit[IDX] = is_wrap & bank_hit;

      act_bank_timer #(.AGE_W(TRC_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .act_i      (act_hit[IDX]),
        .wrap_i     (wrap_hit[IDX]),
        .cfg_trc_i  (cfg_trc),
        .cfg_twrc_i (cfg_twrc),
        .ok_o       (bank_ok[IDX])
      );

      assign bank_ready[IDX] = bank_ok[IDX] & ref_clr[r] & rrd_clr[r];
    end

    assign rank_ready[r] = (&bank_ok[r*NUM_BANKS +: NUM_BANKS]) & ref_clr[r] & rrd_clr[r];
  end

  assign early = (|(act_hit & ~bank_ready)) | (|(ref_hit & ~rank_ready));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) viol_q <= 1'b0;
    else            viol_q <= early;
  end

  assign violation = viol_q;
  assign tal_out   = cfg_tal;

  // R7: a violation is only ever caused by an activate or a refresh
  a_r7_viol_source: assert property (@(posedge clk) disable iff (!rst_int_n)
    violation |-> ($past(op) == OP_ACT || $past(op) == OP_REF));
  // R5: a ready rank implies all of its banks are ready
  a_r5_rank_implies_banks: assert property (@(posedge clk) disable iff (!rst_int_n)
    rank_ready[0] |-> &bank_ready[NUM_BANKS-1:0]);
endmodule

// File: tb/dram_act_guard_tb.sv
module dram_act_guard_tb;
  localparam int NR = 2;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmd_op;
  logic [0:0] cmd_rank;
  logic [1:0] cmd_bank;
  logic [5:0] cfg_trc, cfg_twrc;
  logic [7:0] cfg_trfc;
  logic [3:0] cfg_trrd;
  logic [2:0] cfg_tal;
  wire  [NR*NB-1:0] bank_ready;
  wire  [NR-1:0]    rank_ready;
  wire              violation;
  wire  [2:0]       tal_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int m_age[NR][NB];
  int m_lim[NR][NB];
  int m_ref[NR];
  int m_rrd[NR];
  bit exp_viol;

  always #10 clk = ~clk;

  dram_act_guard #(.NUM_RANKS(NR), .NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .cfg_trc(cfg_trc), .cfg_twrc(cfg_twrc), .cfg_trfc(cfg_trfc), .cfg_trrd(cfg_trrd),
    .cfg_tal(cfg_tal), .bank_ready(bank_ready), .rank_ready(rank_ready),
    .violation(violation), .tal_out(tal_out)
  );

  function automatic int sub1(int v); return (v > 0) ? v - 1 : 0; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  function automatic bit m_bank_ok(int r, int b);
    return (m_age[r][b] >= m_lim[r][b]) && (m_ref[r] == 0) && (m_rrd[r] == 0);
  endfunction

  function automatic bit m_rank_ok(int r);
    bit ok = (m_ref[r] == 0) && (m_rrd[r] == 0);
    for (int b = 0; b < NB; b++) if (m_age[r][b] < m_lim[r][b]) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_ref[r] = 0;
      m_rrd[r] = 0;
      for (int b = 0; b < NB; b++) begin
        m_age[r][b] = 63;
        m_lim[r][b] = 0;
      end
    end
    exp_viol = 1'b0;
  endtask

  task automatic check_outputs();
    int eb = 0;
    int er = 0;
    for (int r = 0; r < NR; r++) begin
      if (m_rank_ok(r)) er |= (1 << r);
      for (int b = 0; b < NB; b++) if (m_bank_ok(r, b)) eb |= (1 << (r*NB + b));
    end
    check("R1 R2 R3 R4 R6 bank_ready", int'(bank_ready), eb);
    check("R3 R5 rank_ready", int'(rank_ready), er);
    check("R7 violation", int'(violation), int'(exp_viol));
    check("R9 tal_out", int'(tal_out), int'(cfg_tal));
  endtask

  // called at a falling edge; the command is taken on the next rising edge
  task automatic step(int op, int r, int b);
    check_outputs();
    exp_viol = (op == 1 && !m_bank_ok(r, b)) || (op == 3 && !m_rank_ok(r));
    cmd_op   = 2'(op);
    cmd_rank = 1'(r);
    cmd_bank = 2'(b);
    for (int rr = 0; rr < NR; rr++) begin
      m_ref[rr] = (op == 3 && rr == r) ? imax(sub1(m_ref[rr]), sub1(cfg_trfc)) : sub1(m_ref[rr]);
      m_rrd[rr] = (op == 1 && rr == r) ? imax(sub1(m_rrd[rr]), sub1(cfg_trrd)) : sub1(m_rrd[rr]);
      for (int bb = 0; bb < NB; bb++) begin
        if (op == 1 && rr == r && bb == b) begin
          int rem = (m_lim[rr][bb] > m_age[rr][bb]) ? m_lim[rr][bb] - m_age[rr][bb] : 0;
          m_lim[rr][bb] = imax(int'(cfg_trc), rem);
          m_age[rr][bb] = 1;
        end else begin
          if (m_age[rr][bb] < 63) m_age[rr][bb]++;
          if (op == 2 && rr == r && bb == b) m_lim[rr][bb] = imax(m_lim[rr][bb], int'(cfg_twrc));
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13579));
    rst_n = 1'b0; cmd_op = 2'b00; cmd_rank = '0; cmd_bank = '0;
    cfg_trc = 6'd5; cfg_twrc = 6'd9; cfg_trfc = 8'd8; cfg_trrd = 4'd2; cfg_tal = 3'd3;
    repeat (3) @(negedge clk);
    check("R8 reset bank_ready", int'(bank_ready), (1 << (NR*NB)) - 1);
    check("R8 reset rank_ready", int'(rank_ready), (1 << NR) - 1);
    check("R8 reset violation", int'(violation), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    check("R8 after reset bank_ready", int'(bank_ready), (1 << (NR*NB)) - 1);

    // R1: same-bank spacing, early issue one cycle short
    step(1, 0, 0); idle(3); step(1, 0, 0); idle(6);
    // R1: exactly on the boundary
    step(1, 0, 0); idle(4); step(1, 0, 0); idle(6);
    // R2: write with page close stretches the spacing from the activate
    step(1, 0, 1); step(2, 0, 1); idle(6); step(1, 0, 1); idle(10);
    // R3 R5: refresh blocks its rank, other rank untouched
    step(3, 1, 0); step(1, 1, 2); step(1, 0, 3); idle(8); step(3, 1, 0); idle(10);
    // R4: cross-bank hold, same and equal expiries
    cfg_trc = 6'd2; cfg_trrd = 4'd2;
    step(1, 0, 0); step(1, 0, 1); step(1, 0, 2); idle(4);
    // R6: new config only at next load; longer remainder kept
    cfg_trc = 6'd12; step(1, 1, 1); cfg_trc = 6'd3; step(1, 1, 1); idle(14);

    for (int i = 0; i < 6000; i++) begin
      int p = $urandom_range(0, 99);
      int r = $urandom_range(0, NR-1);
      int b = $urandom_range(0, NB-1);
      int op = (p < 40) ? 0 : (p < 72) ? 1 : (p < 86) ? 2 : 3;
      if ($urandom_range(0, 49) == 0) begin
        cfg_trc  = 6'($urandom_range(0, 12));
        cfg_twrc = 6'($urandom_range(0, 20));
        cfg_trfc = 8'($urandom_range(0, 25));
        cfg_trrd = 4'($urandom_range(0, 12));
        cfg_tal  = 3'($urandom_range(0, 7));
      end
      step(op, r, b);
    end
    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule